// File: doc/BRIEF.md
# Pipeline Stage Valid/Stall Handshake Chain

A chain of pipeline registers, five deep by default, in which every stage holds one opaque payload word and a valid flag. Each stage works out its own load enable and stall flag from its neighbours. A stage freezes only when it holds live content and the stage after it cannot take that content. Back-pressure therefore starts at the downstream ready input and travels upstream through the occupied stages only. Empty stages keep filling, so the gaps in the pipe close up.

Each stage also has an inject input. When a stage is not frozen and its inject bit is high, it takes a no-op bubble in place of its upstream content. The stages after it keep advancing. The stage before it holds its content, so nothing is dropped. The block targets one item per clock when ready stays high and no bubbles are injected.

Top module: `pipe_hs_chain`

## Requirements
- R1: A synchronous active-high reset clears every stage valid flag, so the cycle after reset shows `stage_valid` = 0 and `out_valid` = 0.
- R2: Stage k reports a stall exactly when it holds valid content and its successor blocks. Stage k+1 blocks when it is stalled or its inject bit `inj[k+1]` is high. The last stage's successor blocks when `out_ready` is low.
- R3: The load enable of stage k is high exactly when the upstream item is valid and stage k is neither stalled nor injected. The upstream item for stage 0 is `in_valid`/`in_data`. `in_ready` is high exactly when stage 0 is neither stalled nor injected.
- R4: A stalled stage keeps its valid flag and its payload unchanged across the clock edge. For the last stage this is visible as a stable `out_data`.
- R5: Bit k of `inj` (bit 0 is the stage nearest the input) makes an unstalled stage k hold no valid content after the edge, while the later stages advance as usual. An inject on a stalled stage has no effect.
- R6: A stage that is not stalled and does not load becomes empty (valid low) after the edge.
- R7: With `out_ready` high, `inj` all zero and `in_valid` held high from an empty pipe, the first item appears at the output N_STAGES cycles after it is accepted, and one item leaves on every clock after that.
- R8: Accepted items leave in acceptance order, with none lost and none duplicated. An injected bubble never appears as a valid output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream item present |
| in_data | input | DATA_W | Upstream payload |
| in_ready | output | 1 | Stage 0 will take the upstream item this cycle |
| inj | input | N_STAGES | Per-stage bubble inject, bit 0 = first stage |
| out_ready | input | 1 | Downstream can take the last stage's item |
| out_valid | output | 1 | Last stage holds a valid item |
| out_data | output | DATA_W | Last stage payload |
| stage_ce | output | N_STAGES | Per-stage load enable |
| stage_valid | output | N_STAGES | Per-stage valid flag |
| stage_stall | output | N_STAGES | Per-stage stall flag |

## Verification
The first pattern is a steady stream with ready held high. It measures the fill latency and the one-per-clock rate, and it would show an extra or missing register in the chain. Random ready with no injects tests whether back-pressure reaches only the occupied stages. A design that froze the whole pipe would lose the gap-closing that the model predicts. Random injects combined with random ready, plus a long full stall and a reset in the middle of the run, separate the correct behaviour from designs that drop or repeat the item beside a bubble, that let an inject override a stalled stage, or that let a bubble appear as output.

// File: rtl/pipe_hs_pkg.sv
package pipe_hs_pkg;

  // Per-stage handshake controls
  typedef struct packed {
    logic ce;     // load enable
    logic stall;  // holding valid content that cannot move
    logic block;  // refuses upstream content (stall or inject)
  } stage_ctl_t;

endpackage

// File: rtl/pipe_hs_ctrl.sv
module pipe_hs_ctrl
  import pipe_hs_pkg::*;
(
  input  logic       my_valid,
  input  logic       up_valid,
  input  logic       dn_block,
  input  logic       inject,
  output stage_ctl_t ctl
);

  always_comb begin
    ctl.stall = my_valid & dn_block;
    ctl.block = ctl.stall | inject;
    ctl.ce    = up_valid & ~ctl.block;
  end

endmodule

// File: rtl/pipe_hs_reg.sv
module pipe_hs_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              hold,
  input  logic [DATA_W-1:0] up_data,
  output logic              valid_q,
  output logic [DATA_W-1:0] data_q
);

  // Valid flag: cleared by reset, frozen on hold, otherwise follows load
  always_ff @(posedge clk) begin
    if (rst)
      valid_q <= 1'b0;
    else if (!hold)
      valid_q <= load;
  end

  // Payload has no reset; written only when new content arrives
  always_ff @(posedge clk) begin
    if (load)
      data_q <= up_data;
  end

endmodule

// File: rtl/pipe_hs_chain.sv
module pipe_hs_chain
  import pipe_hs_pkg::*;
#(
  parameter int N_STAGES = 5,
  parameter int DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [DATA_W-1:0]   in_data,
  output logic                in_ready,
  input  logic [N_STAGES-1:0] inj,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [DATA_W-1:0]   out_data,
  output logic [N_STAGES-1:0] stage_ce,
  output logic [N_STAGES-1:0] stage_valid,
  output logic [N_STAGES-1:0] stage_stall
);

  localparam int LAST = N_STAGES - 1;

  logic [N_STAGES-1:0] vld;
  logic [N_STAGES-1:0] up_v;
  logic [N_STAGES-1:0] dn_blk;
  logic [DATA_W-1:0]   dat  [N_STAGES];
  logic [DATA_W-1:0]   up_d [N_STAGES];
  stage_ctl_t          ctl  [N_STAGES];

  for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign up_v[g] = in_valid;
      assign up_d[g] = in_data;
    end else begin : g_body
      assign up_v[g] = vld[g-1];
      assign up_d[g] = dat[g-1];
    end

    if (g == LAST) begin : g_tail
      assign dn_blk[g] = ~out_ready;
    end else begin : g_mid
      assign dn_blk[g] = ctl[g+1].block;
    end

    pipe_hs_ctrl u_ctrl (
      .my_valid (vld[g]),
      .up_valid (up_v[g]),
      .dn_block (dn_blk[g]),
      .inject   (inj[g]),
      .ctl      (ctl[g])
    );

    pipe_hs_reg #(.DATA_W(DATA_W)) u_reg (
      .clk     (clk),
      .rst     (rst),
      .load    (ctl[g].ce),
      .hold    (ctl[g].stall),
      .up_data (up_d[g]),
      .valid_q (vld[g]),
      .data_q  (dat[g])
    );

    assign stage_ce[g]    = ctl[g].ce;
    assign stage_stall[g] = ctl[g].stall;
  end

  assign stage_valid = vld;
  assign in_ready    = ~ctl[0].block;
  assign out_valid   = vld[LAST];
  assign out_data    = dat[LAST];

endmodule

// File: rtl/pipe_hs_chain_chk.sv
module pipe_hs_chain_chk #(
  parameter int N_STAGES = 5,
  parameter int DATA_W   = 16
) (
  input logic                clk,
  input logic                rst,
  input logic [N_STAGES-1:0] inj,
  input logic                out_valid,
  input logic [DATA_W-1:0]   out_data,
  input logic [N_STAGES-1:0] stage_ce,
  input logic [N_STAGES-1:0] stage_valid,
  input logic [N_STAGES-1:0] stage_stall
);

  localparam int LAST = N_STAGES - 1;

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  always_ff @(posedge clk) begin
    if (rst_d == 1'b1)
      AST_RESET_EMPTY: assert (stage_valid == '0); // R1
  end

  AST_TAIL_HOLD: assert property (@(posedge clk) disable iff (rst)
    stage_stall[LAST] |=> (out_valid && $stable(out_data))); // R4

  for (genvar k = 0; k < N_STAGES; k++) begin : g_chk
    AST_STALL_KEEPS: assert property (@(posedge clk) disable iff (rst)
      stage_stall[k] |=> stage_valid[k]); // R4
    AST_LOAD_FILLS: assert property (@(posedge clk) disable iff (rst)
      stage_ce[k] |=> stage_valid[k]); // R3
    AST_INJECT_EMPTIES: assert property (@(posedge clk) disable iff (rst)
      (inj[k] && !stage_stall[k]) |=> !stage_valid[k]); // R5
    AST_IDLE_DRAINS: assert property (@(posedge clk) disable iff (rst)
      (!stage_stall[k] && !stage_ce[k]) |=> !stage_valid[k]); // R6
  end

endmodule

bind pipe_hs_chain pipe_hs_chain_chk #(.N_STAGES(N_STAGES), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .inj         (inj),
  .out_valid   (out_valid),
  .out_data    (out_data),
  .stage_ce    (stage_ce),
  .stage_valid (stage_valid),
  .stage_stall (stage_stall)
);

// File: tb/pipe_hs_chain_tb.sv
`timescale 1ns/1ps
module pipe_hs_chain_tb;

  localparam int N  = 5;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready;
  logic [N-1:0]  inj = '0;
  logic          out_ready = 1'b0;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic [N-1:0]  stage_ce, stage_valid, stage_stall;

  always #2.5 clk = ~clk;

  pipe_hs_chain #(.N_STAGES(N), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .inj(inj), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .stage_ce(stage_ce),
    .stage_valid(stage_valid), .stage_stall(stage_stall)
  );

  int n_checks = 0;
  int n_fail   = 0;

  // behavioural reference: occupancy and tag per stage
  bit m_v [N];
  int m_d [N];
  int sent_q[$];
  int seq = 0;
  int outs_seen = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model_clear();
    for (int k = 0; k < N; k++) begin
      m_v[k] = 0;
      m_d[k] = 0;
    end
    sent_q.delete();
  endfunction

  // One clock: called at a negedge, returns at the next negedge
  task automatic step(input bit iv, input bit rdy, input logic [N-1:0] ij);
    bit st [N];
    bit bl [N];
    bit ce [N];
    logic [N-1:0] e_st, e_ce, e_v;
    bit e_rdy;
    bit dnb, upv;
    in_valid  = iv;
    in_data   = DW'(seq);
    out_ready = rdy;
    inj       = ij;
    #1;
    for (int k = N - 1; k >= 0; k--) begin
      dnb   = (k == N - 1) ? !rdy : bl[k+1];
      st[k] = m_v[k] && dnb;
      bl[k] = st[k] || ij[k];
      upv   = (k == 0) ? iv : m_v[k-1];
      ce[k] = upv && !bl[k];
      e_st[k] = st[k];
      e_ce[k] = ce[k];
    end
    e_rdy = !bl[0];
    chk(stage_stall == e_st, "R2 stall vector", stage_stall, e_st);
    chk(stage_ce == e_ce, "R3 load enables", stage_ce, e_ce);
    chk(in_ready == e_rdy, "R3 in_ready", in_ready, e_rdy);
    // scoreboard: order, loss, duplication, bubbles
    if (iv && in_ready) begin
      sent_q.push_back(seq);
      seq++;
    end
    if (out_valid && rdy) begin
      outs_seen++;
      if (sent_q.size() == 0)
        chk(0, "R8 output with nothing pending", out_data, 0);
      else
        chk(out_data == DW'(sent_q.pop_front()), "R8 order", out_data, DW'(sent_q[0]));
    end
    @(posedge clk);
    for (int k = N - 1; k >= 0; k--) begin
      if (!st[k]) begin
        m_v[k] = ce[k];
        if (ce[k]) m_d[k] = (k == 0) ? int'(in_data) : m_d[k-1];
      end
    end
    @(negedge clk);
    for (int k = 0; k < N; k++) e_v[k] = m_v[k];
    chk(stage_valid == e_v, "R4 R6 valid flags", stage_valid, e_v);
    for (int k = 0; k < N; k++) begin
      if (ij[k] && !st[k])
        chk(stage_valid[k] == 1'b0, "R5 injected stage empty", stage_valid[k], 0);
    end
    if (m_v[N-1])
      chk(out_data == DW'(m_d[N-1]), "R4 out_data", out_data, DW'(m_d[N-1]));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    inj = '0;
    repeat (2) @(negedge clk);
    model_clear();
    chk(stage_valid == '0 && out_valid == 1'b0, "R1 reset clears valids", stage_valid, 0);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    int first_at;
    int cnt;
    @(negedge clk);
    do_reset();

    // R7: fill latency then one item per clock
    first_at = 0;
    for (int i = 1; i <= N + 2; i++) begin
      step(1, 1, '0);
      if (first_at == 0 && out_valid) first_at = i;
    end
    chk(first_at == N, "R7 fill latency", first_at, N);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      step(1, 1, '0);
      if (out_valid) cnt++;
    end
    chk(cnt == 20, "R7 one per clock", cnt, 20);

    // random back-pressure, no injects (R2, R4, R6)
    for (int i = 0; i < 400; i++)
      step(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)), '0);

    // random injects plus back-pressure (R5, R8)
    for (int i = 0; i < 600; i++) begin
      logic [N-1:0] ij;
      for (int k = 0; k < N; k++) ij[k] = ($urandom_range(0, 9) < 3);
      step(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 2) != 0), ij);
    end

    // long full stall with injects everywhere: injects must not override (R4, R5)
    for (int i = 0; i < 12; i++) step(1, 0, '1);
    for (int i = 0; i < 12; i++) step(1, 0, '0);

    // reset in the middle of a full pipe (R1)
    do_reset();
    for (int i = 0; i < 200; i++)
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), N'($urandom_range(0, 3)));

    // drain and confirm nothing pending (R8)
    for (int i = 0; i < 3 * N; i++) step(0, 1, '0);
    chk(sent_q.size() == 0, "R8 all items delivered", sent_q.size(), 0);
    chk(out_valid == 1'b0 && stage_valid == '0, "R6 empty after drain", stage_valid, 0);
    chk(outs_seen > 100, "R8 traffic observed", outs_seen, 101);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule